// File: doc/BRIEF.md
# Single-Error-Correcting Nibble Codec

This block protects one 4-bit symbol with a 7-bit code in which any two valid words differ in at least three bit positions. The encoder side is purely combinational: it passes the nibble through unchanged in the top four bits of the word and places three check bits below it. Each check bit is the parity of a distinct group of three data bits.

The decoder side takes a received 7-bit word together with a valid strobe. It recomputes the check bits from the received data bits and compares them with the received check bits, which gives a 3-bit syndrome. Every non-zero syndrome points at exactly one of the seven bit positions, so a word with one flipped bit is mapped back to the valid word one bit away. The corrected nibble and a flag that marks a repair appear one clock later, and an output valid that tracks the input valid appears with them. Typical use is on a narrow storage or transport path, with the encoder at the writer and the decoder at the reader on a shared clock.

Top module: `nibble_secc_codec`

## Requirements
- R1: The encoded word carries the data nibble unchanged in bits [6:3], with bit 6 holding data bit 3 and bit 3 holding data bit 0.
- R2: With data bits d3..d0, encoded bit 2 is d3^d2^d1, bit 1 is d3^d2^d0 and bit 0 is d3^d1^d0.
- R3: The encoder gives 0x1->0001011, 0x2->0010101, 0x3->0011110, 0x4->0100110, 0x7->0111000, 0x8->1000111, 0xA->1010010 and 0xF->1111111.
- R4: Any two distinct nibbles encode to words that differ in at least three bit positions.
- R5: A valid received word with no error yields its bits [6:3] as output data with the corrected flag low.
- R6: A valid received word with one flipped bit in positions [6:3] yields the original nibble with the corrected flag high.
- R7: A valid received word with one flipped bit in positions [2:0] yields the unchanged nibble from bits [6:3] with the corrected flag high.
- R8: Decoder data, flag and output valid appear on the clock edge after the edge that samples the input; the output valid equals the input valid sampled one edge earlier.
- R9: While the synchronous active-low reset is applied, output valid, output data and the corrected flag are all zero.
- R10: In a cycle with the input valid low, the output data and the corrected flag keep their previous values, whatever the received word is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the decoder registers |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_data_i | input | 4 | Nibble to encode |
| enc_word_o | output | 7 | Encoded word: nibble in [6:3], check bits in [2:0] |
| dec_valid_i | input | 1 | Received word is present this cycle |
| dec_word_i | input | 7 | Received word, same layout as the encoded word |
| dec_valid_o | output | 1 | Decoded result is present |
| dec_data_o | output | 4 | Decoded, corrected nibble |
| dec_fixed_o | output | 1 | High when a single-bit repair was made |

## Verification
The bench injects every one of the seven single-bit errors into all sixteen codewords, since a swapped syndrome column would repair the wrong bit and return a nibble off by one or two bits, while a wrong check-bit group would corrupt clean words or set the flag on them. Errors confined to the check bits are watched separately: a decoder that treats them as data errors would flip a data bit that was correct. All 120 codeword pairs are compared for distance, which exposes any check equation that lets two nibbles land too close. Latency, the hold behaviour with the input valid low and the reset values are probed at the ports, where a missing register or an unconditional load shows up as data that changes a cycle early or moves with an idle input.

// File: rtl/nibble_secc_codec.sv
module nibble_secc_codec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] enc_data_i,
  output logic [6:0] enc_word_o,
  input  logic       dec_valid_i,
  input  logic [6:0] dec_word_i,
  output logic       dec_valid_o,
  output logic [3:0] dec_data_o,
  output logic       dec_fixed_o
);

  function automatic logic [2:0] checks(input logic [3:0] d);
    return {d[3] ^ d[2] ^ d[1], d[3] ^ d[2] ^ d[0], d[3] ^ d[1] ^ d[0]};
  endfunction

  assign enc_word_o = {enc_data_i, checks(enc_data_i)};

  logic [3:0] rx_data;
  logic [2:0] syndrome;
  logic [3:0] flip_mask;
  logic [3:0] fixed_data;

  assign rx_data  = dec_word_i[6:3];
  assign syndrome = dec_word_i[2:0] ^ checks(rx_data);

  always_comb begin
    case (syndrome)
      3'b111:  flip_mask = 4'b1000;
      3'b110:  flip_mask = 4'b0100;
      3'b101:  flip_mask = 4'b0010;
      3'b011:  flip_mask = 4'b0001;
      default: flip_mask = 4'b0000;
    endcase
  end

  assign fixed_data = rx_data ^ flip_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      dec_data_o  <= 4'd0;
      dec_fixed_o <= 1'b0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_data_o  <= fixed_data;
        dec_fixed_o <= |syndrome;
      end
    end
  end

  // R8: output valid mirrors the input valid one edge later
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dec_valid_o == $past(dec_valid_i));

  // R10: idle input leaves the result untouched
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(dec_valid_i) |-> $stable(dec_data_o) && $stable(dec_fixed_o));

  // R5: no repair means the received nibble passes through
  a_r5_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dec_valid_i) && !dec_fixed_o |-> dec_data_o == $past(dec_word_i[6:3]));

  // R6: a repair changes at most one data bit
  a_r6_one_bit_repair: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dec_valid_i) |-> $countones(dec_data_o ^ $past(dec_word_i[6:3])) <= 1);

  // R9: leaving reset, nothing is reported
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !dec_valid_o && !dec_fixed_o && dec_data_o == 4'd0);

endmodule

// File: tb/nibble_secc_codec_bench.sv
module nibble_secc_codec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] enc_data_i = 4'd0;
  logic [6:0] enc_word_o;
  logic       dec_valid_i = 1'b0;
  logic [6:0] dec_word_i = 7'd0;
  logic       dec_valid_o;
  logic [3:0] dec_data_o;
  logic       dec_fixed_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nibble_secc_codec u_nibble_secc_codec (
    .clk(clk), .rst_n(rst_n), .enc_data_i(enc_data_i), .enc_word_o(enc_word_o),
    .dec_valid_i(dec_valid_i), .dec_word_i(dec_word_i), .dec_valid_o(dec_valid_o),
    .dec_data_o(dec_data_o), .dec_fixed_o(dec_fixed_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_word(input logic [3:0] d);
    return {d, d[3]^d[2]^d[1], d[3]^d[2]^d[0], d[3]^d[1]^d[0]};
  endfunction

  task automatic send(input logic v, input logic [6:0] w);
    @(negedge clk);
    dec_valid_i = v;
    dec_word_i  = w;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    dec_valid_i = 1'b1;
    dec_word_i = 7'b1111110;
    repeat (3) @(posedge clk);
    #1;
    check(dec_valid_o == 1'b0, "R9 valid", dec_valid_o, 0);
    check(dec_data_o == 4'd0, "R9 data", dec_data_o, 0);
    check(dec_fixed_o == 1'b0, "R9 flag", dec_fixed_o, 0);
    @(negedge clk);
    dec_valid_i = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_encode;
    logic [6:0] refs [8];
    logic [3:0] ins [8];
    ins = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h7, 4'h8, 4'hA, 4'hF};
    refs = '{7'b0001011, 7'b0010101, 7'b0011110, 7'b0100110,
             7'b0111000, 7'b1000111, 7'b1010010, 7'b1111111};
    for (int i = 0; i < 8; i++) begin
      enc_data_i = ins[i];
      #1;
      check(enc_word_o == refs[i], "R3 reference word", enc_word_o, refs[i]);
    end
    for (int d = 0; d < 16; d++) begin
      enc_data_i = 4'(d);
      #1;
      check(enc_word_o[6:3] == 4'(d), "R1 data field", enc_word_o[6:3], d);
      check(enc_word_o[2:0] == ref_word(4'(d))[2:0], "R2 check bits",
            enc_word_o[2:0], ref_word(4'(d))[2:0]);
    end
  endtask

  task automatic t_distance;
    logic [6:0] w [16];
    for (int d = 0; d < 16; d++) begin
      enc_data_i = 4'(d);
      #1;
      w[d] = enc_word_o;
    end
    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++)
        check($countones(w[a] ^ w[b]) >= 3, "R4 min distance",
              $countones(w[a] ^ w[b]), 3);
  endtask

  task automatic t_clean;
    for (int d = 0; d < 16; d++) begin
      enc_data_i = 4'(d);
      #1;
      send(1'b1, enc_word_o);
      check(dec_valid_o == 1'b1, "R8 valid out", dec_valid_o, 1);
      check(dec_data_o == 4'(d) && !dec_fixed_o, "R5 clean word",
            {dec_fixed_o, dec_data_o}, d);
    end
  endtask

  task automatic t_single_errors;
    for (int d = 0; d < 16; d++)
      for (int p = 0; p < 7; p++) begin
        send(1'b1, ref_word(4'(d)) ^ (7'd1 << p));
        if (p >= 3)
          check(dec_data_o == 4'(d) && dec_fixed_o, "R6 data bit repair",
                {dec_fixed_o, dec_data_o}, 16 + d);
        else
          check(dec_data_o == 4'(d) && dec_fixed_o, "R7 check bit repair",
                {dec_fixed_o, dec_data_o}, 16 + d);
      end
  endtask

  task automatic t_latency;
    send(1'b0, 7'd0);
    @(negedge clk);
    dec_valid_i = 1'b1;
    dec_word_i = ref_word(4'h9);
    #1;
    check(dec_valid_o == 1'b0, "R8 no early valid", dec_valid_o, 0);
    check(dec_data_o != 4'h9, "R8 no early data", dec_data_o, 0);
    @(posedge clk);
    #1;
    check(dec_valid_o == 1'b1 && dec_data_o == 4'h9, "R8 one cycle latency",
          {dec_valid_o, dec_data_o}, 16 + 9);
  endtask

  task automatic t_hold;
    send(1'b1, ref_word(4'h6) ^ 7'b0000001);
    check(dec_data_o == 4'h6 && dec_fixed_o, "R10 setup", {dec_fixed_o, dec_data_o}, 16 + 6);
    send(1'b0, ref_word(4'hC) ^ 7'b0100000);
    check(dec_valid_o == 1'b0, "R10 valid low", dec_valid_o, 0);
    check(dec_data_o == 4'h6 && dec_fixed_o, "R10 held result", {dec_fixed_o, dec_data_o}, 16 + 6);
    send(1'b0, ref_word(4'h3));
    check(dec_data_o == 4'h6 && dec_fixed_o, "R10 still held", {dec_fixed_o, dec_data_o}, 16 + 6);
  endtask

  initial begin
    t_reset();
    t_encode();
    t_distance();
    t_clean();
    t_single_errors();
    t_latency();
    t_hold();
    send(1'b0, 7'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule